// File: doc/BRIEF.md
# Power Domain Sequencer with Bus-Quiesce Handshake

This block controls a set of switchable power domains. Software writes one target bit per domain into a register file through a zero-wait-state APB-style port. For each domain a sequencer carries out the change in a fixed order. Going down, it first asks the domain's bus interface to go quiet and waits for that interface's acknowledge and then its idle flag. Only then does it open the power switch and count a programmable settle time. Coming up, it reverses the order: it closes the switch and counts the up time, then withdraws the quiesce request and waits for acknowledge and idle to clear.

The per-domain result appears in a status register, where 1 means off. Domains may be of three kinds, chosen by two parameter masks. A full domain has both a switch and a handshake. A switch-only domain has a power switch but no quiesce handshake. A handshake-only domain has a quiesce handshake and no switch; its status simply follows its live idle flag.

Software may rewrite a target while a sequence is still running. The new value shows up in the register at once, but the sequencer only acts on it once the current sequence has finished.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, the control register (0x08), the status register (0x0c) and the request readback (0x10) read 0, `idleReq` and `pwrOff` are low, and every transition-count register reads 24.
- R2: When a full domain's control bit d (1 = off) is written to 1, `idleReq[d]` rises on the clock edge after the edge that accepts the write, while `pwrOff[d]` stays low.
- R3: `pwrOff[d]` of a full domain rises only on an edge where `busIdle[d]` is sampled high, and only after `busAck[d]` has been sampled high since the request rose.
- R4: Status bit d (1 = off, 0 = on) sets on the (N+1)-th edge after the edge on which `pwrOff[d]` rose, where N is that domain's down count.
- R5: When control bit d is written to 0 on a powered-off domain, `pwrOff[d]` falls on the next edge. Status bit d clears N+1 edges later, with N the up count, and `idleReq[d]` falls on that same edge. The domain takes no new request until `busAck[d]` and then `busIdle[d]` have been sampled low.
- R6: A handshake-only domain (default: domain 3) takes its target from bit d of 0x10 (1 = quiesce). Its status bit equals the live `busIdle[d]`, and its `pwrOff[d]` never rises.
- R7: A switch-only domain (default: domain 2) never raises `idleReq[d]`. Its `pwrOff[d]` changes on the edge after the write edge.
- R8: Register 0x14 is read-only. Bit d holds `busIdle[d]` and bit d+16 holds `busAck[d]`. Register 0x10 reads back the live `idleReq` vector.
- R9: Domain d's down count sits at 0x34+8d and its up count at 0x38+8d. Each holds an independent CNT_W-bit value. A count of 0 sets status on the first edge after the switch edge. Addresses of domains without a switch read 0.
- R10: Writes to 0x0c and 0x14 are ignored. Control bits of handshake-only domains are ignored and read 0. Bits of 0x10 that belong to switched domains are ignored.
- R11: A target written while a sequence runs reads back at once. The running sequence completes unchanged, and the new target is acted on afterwards.
- R12: An access writes on the edge where `psel`, `penable` and `pwrite` are all high. `prdata` follows `paddr` combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Register access select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| busAck | input | NUM_DOM | Per-domain quiesce acknowledge |
| busIdle | input | NUM_DOM | Per-domain bus idle flag |
| idleReq | output | NUM_DOM | Per-domain quiesce request |
| pwrOff | output | NUM_DOM | Per-domain power switch, 1 = open (off) |

## Verification
The quiesce request is due one edge after the write edge. The switch moves on the very edge where idle is sampled, or one edge after the write for switch-only domains. Status follows N+1 edges after the switch moves. A behavioural model in the bench steps once per clock, 1 ns after each rising edge, using the inputs the design saw at that edge. It compares `idleReq` and `pwrOff` on every cycle, so each of these delays is checked to the exact edge. Register reads are combinational and are sampled at falling edges, so status, readback and flag values are compared against the model in the same cycle they are read.

// File: rtl/pds_pkg.sv
package pds_pkg;

  // Fixed register map; the count block is indexed by domain.
  localparam int ADR_CTRL     = 'h08;
  localparam int ADR_STATUS   = 'h0c;
  localparam int ADR_REQ      = 'h10;
  localparam int ADR_FLAGS    = 'h14;
  localparam int ADR_CNT_BASE = 'h34;
  localparam int CNT_STRIDE   = 8;
  localparam int UP_OFFSET    = 4;
  localparam int ACK_SHIFT    = 16;

  // Strobes from a domain sequencer to the datapath.
  typedef struct packed {
    logic loadDown;
    logic loadUp;
    logic setOff;
    logic setOn;
  } pds_strobe_t;

  typedef enum logic [2:0] {
    ST_ON, ST_REQ, ST_DRAIN, ST_DOWN, ST_OFF, ST_UP, ST_REL, ST_RELIDLE
  } pds_state_t;

endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int                 NUM_DOM = 4,
  parameter logic [NUM_DOM-1:0] HAS_PWR = 4'b0111,
  parameter logic [NUM_DOM-1:0] HAS_REQ = 4'b1011
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_DOM-1:0]         target,
  input  logic [NUM_DOM-1:0]         cntZero,
  input  logic [NUM_DOM-1:0]         busAck,
  input  logic [NUM_DOM-1:0]         busIdle,
  output logic [NUM_DOM-1:0]         idleReq,
  output logic [NUM_DOM-1:0]         pwrOff,
  output pds_strobe_t [NUM_DOM-1:0]  strb
);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam bit PWR = HAS_PWR[d];
    localparam bit REQ = HAS_REQ[d];

    pds_state_t  st, stNext;
    logic        reqQ, reqNext, offQ, offNext;
    pds_strobe_t s;

    always_comb begin
      stNext  = st;
      reqNext = reqQ;
      offNext = offQ;
      s       = '0;
      case (st)
        ST_ON: begin
          if (target[d]) begin
            if (REQ) begin
              reqNext = 1'b1;
              stNext  = ST_REQ;
            end else begin
              offNext    = 1'b1;
              s.loadDown = 1'b1;
              stNext     = ST_DOWN;
            end
          end
        end
        ST_REQ: if (busAck[d]) stNext = ST_DRAIN;
        ST_DRAIN: begin
          if (busIdle[d]) begin
            if (PWR) begin
              offNext    = 1'b1;
              s.loadDown = 1'b1;
              stNext     = ST_DOWN;
            end else begin
              stNext = ST_OFF;
            end
          end
        end
        ST_DOWN: begin
          if (cntZero[d]) begin
            s.setOff = 1'b1;
            stNext   = ST_OFF;
          end
        end
        ST_OFF: begin
          if (!target[d]) begin
            if (PWR) begin
              offNext  = 1'b0;
              s.loadUp = 1'b1;
              stNext   = ST_UP;
            end else begin
              reqNext = 1'b0;
              stNext  = ST_REL;
            end
          end
        end
        ST_UP: begin
          if (cntZero[d]) begin
            s.setOn = 1'b1;
            if (REQ) begin
              reqNext = 1'b0;
              stNext  = ST_REL;
            end else begin
              stNext = ST_ON;
            end
          end
        end
        ST_REL:     if (!busAck[d])  stNext = ST_RELIDLE;
        ST_RELIDLE: if (!busIdle[d]) stNext = ST_ON;
        default:    stNext = ST_ON;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st   <= ST_ON;
        reqQ <= 1'b0;
        offQ <= 1'b0;
      end else begin
        st   <= stNext;
        reqQ <= reqNext;
        offQ <= offNext;
      end
    end

    assign idleReq[d] = reqQ;
    assign pwrOff[d]  = offQ;
    assign strb[d]    = s;
  end

endmodule

// File: rtl/pds_datapath.sv
module pds_datapath
  import pds_pkg::*;
#(
  parameter int                 NUM_DOM   = 4,
  parameter logic [NUM_DOM-1:0] HAS_PWR   = 4'b0111,
  parameter int                 ADDR_W    = 8,
  parameter int                 CNT_W     = 16,
  parameter int                 CNT_RESET = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [31:0]               pwdata,
  output logic [31:0]               prdata,
  input  pds_strobe_t [NUM_DOM-1:0] strb,
  input  logic [NUM_DOM-1:0]        busAck,
  input  logic [NUM_DOM-1:0]        busIdle,
  input  logic [NUM_DOM-1:0]        idleReq,
  output logic [NUM_DOM-1:0]        target,
  output logic [NUM_DOM-1:0]        cntZero,
  output logic [NUM_DOM-1:0]        statusBits
);

  localparam logic [NUM_DOM-1:0] HS_ONLY = ~HAS_PWR;
  localparam logic [ADDR_W-1:0]  A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0]  A_STAT  = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0]  A_REQ   = ADDR_W'(ADR_REQ);
  localparam logic [ADDR_W-1:0]  A_FLAGS = ADDR_W'(ADR_FLAGS);

  logic wrEn;
  assign wrEn = psel & penable & pwrite;

  // Target bits: switched domains from the control word, others from 0x10.
  logic [NUM_DOM-1:0] tgtQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      tgtQ <= '0;
    end else if (wrEn) begin
      if (paddr == A_CTRL)
        tgtQ <= (tgtQ & HS_ONLY) | (pwdata[NUM_DOM-1:0] & HAS_PWR);
      else if (paddr == A_REQ)
        tgtQ <= (tgtQ & HAS_PWR) | (pwdata[NUM_DOM-1:0] & HS_ONLY);
    end
  end
  assign target = tgtQ;

  logic [NUM_DOM-1:0][CNT_W-1:0] downView, upView;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_cnt
    if (HAS_PWR[d]) begin : g_sw
      localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(ADR_CNT_BASE + CNT_STRIDE * d);
      localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(ADR_CNT_BASE + CNT_STRIDE * d + UP_OFFSET);

      logic [CNT_W-1:0] downQ, upQ, cntQ;
      logic             offQ;

      always_ff @(posedge clk) begin
        if (rst) begin
          downQ <= CNT_W'(CNT_RESET);
          upQ   <= CNT_W'(CNT_RESET);
        end else if (wrEn) begin
          if (paddr == A_DOWN) downQ <= pwdata[CNT_W-1:0];
          if (paddr == A_UP)   upQ   <= pwdata[CNT_W-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (rst)                  cntQ <= '0;
        else if (strb[d].loadDown) cntQ <= downQ;
        else if (strb[d].loadUp)   cntQ <= upQ;
        else if (cntQ != '0)       cntQ <= cntQ - 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst)                 offQ <= 1'b0;
        else if (strb[d].setOff) offQ <= 1'b1;
        else if (strb[d].setOn)  offQ <= 1'b0;
      end

      assign downView[d]   = downQ;
      assign upView[d]     = upQ;
      assign cntZero[d]    = (cntQ == '0);
      assign statusBits[d] = offQ;
    end else begin : g_hs
      assign downView[d]   = '0;
      assign upView[d]     = '0;
      assign cntZero[d]    = 1'b1;
      assign statusBits[d] = busIdle[d];
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_CTRL) begin
      prdata[NUM_DOM-1:0] = tgtQ & HAS_PWR;
    end else if (paddr == A_STAT) begin
      prdata[NUM_DOM-1:0] = statusBits;
    end else if (paddr == A_REQ) begin
      prdata[NUM_DOM-1:0] = idleReq;
    end else if (paddr == A_FLAGS) begin
      prdata[NUM_DOM-1:0]           = busIdle;
      prdata[ACK_SHIFT +: NUM_DOM]  = busAck;
    end else begin
      for (int d = 0; d < NUM_DOM; d++) begin
        if (paddr == ADDR_W'(ADR_CNT_BASE + CNT_STRIDE * d))
          prdata[CNT_W-1:0] = downView[d];
        if (paddr == ADDR_W'(ADR_CNT_BASE + CNT_STRIDE * d + UP_OFFSET))
          prdata[CNT_W-1:0] = upView[d];
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{pwdata, strb};

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int                 NUM_DOM   = 4,
  parameter logic [NUM_DOM-1:0] HAS_PWR   = 4'b0111,
  parameter logic [NUM_DOM-1:0] HAS_REQ   = 4'b1011,
  parameter int                 ADDR_W    = 8,
  parameter int                 CNT_W     = 16,
  parameter int                 CNT_RESET = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  input  logic [NUM_DOM-1:0] busAck,
  input  logic [NUM_DOM-1:0] busIdle,
  output logic [NUM_DOM-1:0] idleReq,
  output logic [NUM_DOM-1:0] pwrOff
);

  pds_strobe_t [NUM_DOM-1:0] strb;
  logic [NUM_DOM-1:0]        target, cntZero, statusBits;

  pds_ctrl #(
    .NUM_DOM(NUM_DOM), .HAS_PWR(HAS_PWR), .HAS_REQ(HAS_REQ)
  ) u_ctrl (
    .clk(clk), .rst(rst), .target(target), .cntZero(cntZero),
    .busAck(busAck), .busIdle(busIdle), .idleReq(idleReq),
    .pwrOff(pwrOff), .strb(strb)
  );

  pds_datapath #(
    .NUM_DOM(NUM_DOM), .HAS_PWR(HAS_PWR), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .CNT_RESET(CNT_RESET)
  ) u_dp (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .strb(strb),
    .busAck(busAck), .busIdle(busIdle), .idleReq(idleReq),
    .target(target), .cntZero(cntZero), .statusBits(statusBits)
  );

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int                 NUM_DOM = 4,
  parameter logic [NUM_DOM-1:0] HAS_PWR = 4'b0111,
  parameter logic [NUM_DOM-1:0] HAS_REQ = 4'b1011
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DOM-1:0] idleReq,
  input logic [NUM_DOM-1:0] pwrOff,
  input logic [NUM_DOM-1:0] busIdle,
  input logic [NUM_DOM-1:0] statusBits
);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
    if (HAS_PWR[d] && HAS_REQ[d]) begin : g_full
      a_r2_request_before_switch: assert property (@(posedge clk) disable iff (rst)
        $rose(idleReq[d]) |-> !pwrOff[d]);
      a_r3_switch_after_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrOff[d]) |-> idleReq[d] && $past(busIdle[d]));
      a_r5_release_after_power: assert property (@(posedge clk) disable iff (rst)
        $fell(idleReq[d]) |-> !pwrOff[d] && !statusBits[d]);
    end
    if (HAS_PWR[d]) begin : g_sw
      a_r4_off_needs_switch: assert property (@(posedge clk) disable iff (rst)
        $rose(statusBits[d]) |-> pwrOff[d]);
      a_r5_on_needs_switch: assert property (@(posedge clk) disable iff (rst)
        $fell(statusBits[d]) |-> !pwrOff[d]);
    end
  end

endmodule

bind pwr_domain_seq pds_checker #(
  .NUM_DOM(NUM_DOM), .HAS_PWR(HAS_PWR), .HAS_REQ(HAS_REQ)
) u_chk (
  .clk(clk), .rst(rst), .idleReq(idleReq), .pwrOff(pwrOff),
  .busIdle(busIdle), .statusBits(statusBits)
);

// File: tb/sim_pwr_domain_seq.sv
`timescale 1ns/1ps
module sim_pwr_domain_seq;
  localparam int N = 4;
  localparam logic [N-1:0] HP = 4'b0111;
  localparam logic [N-1:0] HQ = 4'b1011;
  localparam int DRAIN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N-1:0] busAck = '0, busIdle = '0;
  logic [N-1:0] idleReq, pwrOff;

  pwr_domain_seq u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busAck(busAck),
    .busIdle(busIdle), .idleReq(idleReq), .pwrOff(pwrOff)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 0, sawOff0 = 0;

  // Behavioural reference: phase 0 on,1 wait ack,2 wait idle,3 down count,
  // 4 off,5 up count,6 wait ack low,7 wait idle low.
  int ph[N], tm[N], mDown[N], mUp[N], drain[N];
  logic [N-1:0] mTgt, mReq, mOff, mSt;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  task automatic modelReset();
    for (int d = 0; d < N; d++) begin
      ph[d] = 0; tm[d] = 0; mDown[d] = 24; mUp[d] = 24; drain[d] = 0;
    end
    mTgt = '0; mReq = '0; mOff = '0; mSt = '0;
    busAck = '0; busIdle = '0;
  endtask

  task automatic modelStep();
    for (int d = 0; d < N; d++) begin
      case (ph[d])
        0: if (mTgt[d]) begin
             if (HQ[d]) begin mReq[d] = 1; ph[d] = 1; end
             else begin mOff[d] = 1; tm[d] = mDown[d]; ph[d] = 3; end
           end
        1: if (busAck[d]) ph[d] = 2;
        2: if (busIdle[d]) begin
             if (HP[d]) begin mOff[d] = 1; tm[d] = mDown[d]; ph[d] = 3; end
             else ph[d] = 4;
           end
        3: if (tm[d] == 0) begin mSt[d] = 1; ph[d] = 4; end else tm[d]--;
        4: if (!mTgt[d]) begin
             if (HP[d]) begin mOff[d] = 0; tm[d] = mUp[d]; ph[d] = 5; end
             else begin mReq[d] = 0; ph[d] = 6; end
           end
        5: if (tm[d] == 0) begin
             mSt[d] = 0;
             if (HQ[d]) begin mReq[d] = 0; ph[d] = 6; end else ph[d] = 0;
           end else tm[d]--;
        6: if (!busAck[d]) ph[d] = 7;
        7: if (!busIdle[d]) ph[d] = 0;
        default: ph[d] = 0;
      endcase
    end
  endtask

  task automatic modelWrite(int a, logic [31:0] v);
    if (a == 'h08) mTgt = (mTgt & ~HP) | (v[N-1:0] & HP);
    if (a == 'h10) mTgt = (mTgt & HP) | (v[N-1:0] & ~HP);
    for (int d = 0; d < N; d++) if (HP[d]) begin
      if (a == 'h34 + 8*d) mDown[d] = int'(v[15:0]);
      if (a == 'h38 + 8*d) mUp[d] = int'(v[15:0]);
    end
  endtask

  task automatic busStep();
    for (int d = 0; d < N; d++) begin
      if (idleReq[d]) begin
        if (busAck[d]) begin
          drain[d]++;
          if (drain[d] >= DRAIN) busIdle[d] = 1;
        end
        busAck[d] = 1;
      end else begin
        if (!busAck[d]) begin busIdle[d] = 0; drain[d] = 0; end
        busAck[d] = 0;
      end
    end
  endtask

  // Per-cycle comparison 1 ns after each rising edge (R2 R3 R4 R5 R6 R7).
  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (rst) begin
      modelReset();
    end else begin
      modelStep();
      if (psel && penable && pwrite) modelWrite(int'(paddr), pwdata);
      check(idleReq === mReq, "R2 R5 R7 idleReq", 32'(idleReq), 32'(mReq));
      check(pwrOff === mOff, "R3 R4 R6 pwrOff", 32'(pwrOff), 32'(mOff));
      if (pwrOff[0]) sawOff0 = 1;
      busStep();
    end
    if (cyc > 100000 && !done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic apbWrite(logic [7:0] a, logic [31:0] v);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    #1 v = prdata;
    psel = 0;
  endtask

  function automatic bit quiet();
    for (int d = 0; d < N; d++)
      if (!((ph[d] == 0 && !mTgt[d]) || (ph[d] == 4 && mTgt[d]))) return 0;
    return busAck === idleReq;
  endfunction

  task automatic settle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (quiet()) break;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] r = '0;
    for (int d = 0; d < N; d++) r[d] = HP[d] ? mSt[d] : busIdle[d];
    return r;
  endfunction

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state, R12 combinational read
    apbRead(8'h08, rd); check(rd == 0, "R1 ctrl reset", rd, 0);
    apbRead(8'h0c, rd); check(rd == 0, "R1 status reset", rd, 0);
    apbRead(8'h10, rd); check(rd == 0, "R1 R12 req reset", rd, 0);
    apbRead(8'h34, rd); check(rd == 24, "R1 down count reset", rd, 24);
    apbRead(8'h48, rd); check(rd == 24, "R1 up count reset", rd, 24);
    check(idleReq == 0 && pwrOff == 0, "R1 outputs reset", {idleReq, pwrOff}, 0);

    // R9 count registers, independent up/down
    apbWrite(8'h34, 5); apbWrite(8'h38, 3); apbWrite(8'h3c, 2); apbWrite(8'h44, 0);
    apbRead(8'h34, rd); check(rd == 5, "R9 dom0 down", rd, 5);
    apbRead(8'h38, rd); check(rd == 3, "R9 dom0 up", rd, 3);
    apbRead(8'h40, rd); check(rd == 24, "R9 dom1 up untouched", rd, 24);
    apbRead(8'h44, rd); check(rd == 0, "R9 dom2 down zero", rd, 0);
    apbRead(8'h4c, rd); check(rd == 0, "R9 handshake-only count", rd, 0);

    // R2 R3 R4 full domain down
    apbWrite(8'h08, 32'h1); settle();
    apbRead(8'h0c, rd); check(rd == expStatus() && rd[0], "R4 dom0 off", rd, expStatus());

    // R10 handshake-only bit in ctrl ignored; R7 switch-only; R9 zero count
    apbWrite(8'h08, 32'hF); settle();
    apbRead(8'h08, rd); check(rd == 32'h7, "R10 ctrl hs bit ignored", rd, 32'h7);
    apbRead(8'h0c, rd); check(rd == 32'h7, "R4 R7 status three off", rd, 32'h7);

    // R6 handshake-only down, R10 switched bits in 0x10 ignored
    apbWrite(8'h10, 32'h9); settle();
    apbRead(8'h0c, rd); check(rd == 32'hF && rd == expStatus(), "R6 hs status follows idle", rd, 32'hF);
    apbRead(8'h10, rd); check(rd == 32'(mReq), "R8 request readback", rd, 32'(mReq));
    apbRead(8'h14, rd);
    check(rd == (32'(busIdle) | (32'(busAck) << 16)), "R8 flags", rd, 32'(busIdle) | (32'(busAck) << 16));

    // R10 read-only registers ignore writes
    apbWrite(8'h0c, 0); apbWrite(8'h14, 0);
    apbRead(8'h0c, rd); check(rd == 32'hF, "R10 status write ignored", rd, 32'hF);
    apbRead(8'h14, rd);
    check(rd == (32'(busIdle) | (32'(busAck) << 16)), "R10 flags write ignored", rd, 32'(busIdle) | (32'(busAck) << 16));

    // R5 power up of switched domains
    apbWrite(8'h08, 0); settle();
    apbRead(8'h0c, rd); check(rd == 32'h8, "R5 switched domains on", rd, 32'h8);
    apbWrite(8'h10, 0); settle();
    apbRead(8'h0c, rd); check(rd == 0, "R6 hs domain on", rd, 0);

    // R11 write during transition held
    sawOff0 = 0;
    apbWrite(8'h08, 32'h1);
    repeat (2) @(negedge clk);
    apbWrite(8'h08, 32'h0);
    apbRead(8'h08, rd); check(rd == 0, "R11 immediate readback", rd, 0);
    settle();
    check(sawOff0, "R11 sequence completed before reversal", 32'(sawOff0), 1);
    apbRead(8'h0c, rd); check(rd == 0, "R11 final on", rd, 0);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule